// File: doc/BRIEF.md
# Four-Way Set-Associative Cache with True LRU

This block is a small read/write cache that sits between a processor port and a block-oriented memory. A request carries a byte address. The low bits of the address pick a word within a 16-byte line of four 32-bit words. The next bits pick a set, and the remaining upper bits form the tag. All four ways of the chosen set are compared against the tag in the same cycle, and the matching way drives the response word.

On a read miss the block asks memory for the whole line, installs it in one way of the set and answers with the requested word. The line goes into the lowest-numbered empty way if there is one. Otherwise it replaces the least recently used way. Each set keeps a 2-bit age per way, where 0 is the newest and 3 the oldest.

Writes go straight through to memory. A write hit also updates the cached word. A write miss leaves the cache untouched.

Top module: `cache_4way`

## Requirements
- R1: The set is the block address modulo the set count: with 4 sets, byte address bits [5:4] select the set, bits [3:2] the word and bits [31:6] the tag. A refill request carries the block-aligned address, with the low 4 bits at zero.
- R2: A read hit raises `respValid` with `respHit`=1 and the stored word in the cycle after acceptance, without any memory request.
- R3: A hit is reported only when exactly one way of the set is valid and matches the tag.
- R4: A read miss holds `memReqValid` until `memRefillValid`. In that cycle it answers with `respHit`=0 and word k of the line, taken from `memRefillData` bits [32k+31:32k], and it installs the line so that later reads of any word of the block hit.
- R5: While a set has an empty way, a fill goes to the lowest-numbered empty way, so four distinct blocks of one set all stay resident.
- R6: When a set is full, a read miss replaces the way used least recently, counting both hits and fills as uses.
- R7: Reset clears every valid bit and sets each set's way ages to 0,1,2,3. A hit or fill sets the used way's age to 0 and adds one to every way that was younger than it.
- R8: A write hit raises `memWrValid` with the request address and data in the same cycle as its response (`respHit`=1). Later reads return the new word.
- R9: A write miss raises `memWrValid` and answers with `respHit`=0. It never requests a refill and allocates nothing, so a later read of that address misses.
- R10: `reqReady` is high after reset and whenever the block is idle, and it is low while a request is being handled. After reset `respValid`, `memReqValid` and `memWrValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Processor request present |
| reqReady | output | 1 | Block can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 32 | Byte address |
| reqWdata | input | 32 | Write word |
| respValid | output | 1 | Response strobe, one cycle |
| respHit | output | 1 | Response came from a cached line |
| respRdata | output | 32 | Read word |
| memReqValid | output | 1 | Line refill request, held until served |
| memReqAddr | output | 32 | Block-aligned refill address |
| memRefillValid | input | 1 | Refill line present |
| memRefillData | input | 128 | Refill line, word 0 in the low bits |
| memWrValid | output | 1 | Write-through strobe |
| memWrAddr | output | 32 | Write-through address |
| memWrData | output | 32 | Write-through word |

## Verification
The hardest case to reach is a replacement that only a full and correctly ordered age state can explain. The ports never show which way holds a block, so the age order has to be inferred from which block disappears. The stimulus fills one set with four blocks, re-touches the oldest one, and then forces a miss. After that it probes every resident block in a chosen order and misses on the block that must have been evicted. Each probe is itself a use, so the expected victim at every step is worked out by hand from the age rule.

// File: rtl/cache_pkg.sv
package cache_pkg;
  localparam int WAYS  = 4;
  localparam int WAY_W = 2;

  typedef logic [WAY_W-1:0] wayIdx_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic touchHit;
    logic writeWord;
    logic fill;
  } ctrlStrobe_t;

  // lookup status back to control
  typedef struct packed {
    logic hit;
    logic write;
  } lookupStat_t;
endpackage

// File: rtl/cache_lru.sv
module cache_lru
  import cache_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int SET_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SET_W-1:0] setIdx,
  input  logic             touch,
  input  wayIdx_t          touchWay,
  input  logic [WAYS-1:0]  validVec,
  output wayIdx_t          victimWay
);
  logic [WAY_W-1:0] ages [SETS][WAYS];
  logic [WAY_W-1:0] oldAge;

  assign oldAge = ages[setIdx][touchWay];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          ages[s][w] <= WAY_W'(w);
    end else if (touch) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touchWay)
          ages[setIdx][w] <= '0;
        else if (ages[setIdx][w] < oldAge)
          ages[setIdx][w] <= ages[setIdx][w] + 1'b1;
      end
    end
  end

  // lowest empty way first, else the oldest way
  always_comb begin
    logic found;
    found = 1'b0;
    victimWay = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !validVec[w]) begin
        victimWay = WAY_W'(w);
        found = 1'b1;
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++)
        if (ages[setIdx][w] == WAY_W'(WAYS - 1)) victimWay = WAY_W'(w);
    end
  end

  // each set must hold a permutation of the ages
  for (genvar s = 0; s < SETS; s++) begin : g_ageCheck
    logic [WAYS-1:0] ageMask;
    always_comb begin
      ageMask = '0;
      for (int w = 0; w < WAYS; w++) ageMask[ages[s][w]] = 1'b1;
    end
    assert_ages_perm_R7: assert property (@(posedge clk) disable iff (!rstN)
      ageMask == {WAYS{1'b1}});
  end

  assert_touch_youngest_R7: assert property (@(posedge clk) disable iff (!rstN)
    touch |=> ages[$past(setIdx)][$past(touchWay)] == '0);

  assert_victim_empty_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(&validVec) |-> !validVec[victimWay]);
endmodule

// File: rtl/cache_datapath.sv
module cache_datapath
  import cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int SETS   = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobe_t             strobe,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic                    reqWrite,
  input  logic [DATA_W-1:0]       reqWdata,
  input  logic [WORDS*DATA_W-1:0] memRefillData,
  output lookupStat_t             stat,
  output logic [DATA_W-1:0]       respRdata,
  output logic [ADDR_W-1:0]       memReqAddr,
  output logic [ADDR_W-1:0]       memWrAddr,
  output logic [DATA_W-1:0]       memWrData
);
  localparam int LINE_W = WORDS * DATA_W;
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int WSEL_W = $clog2(WORDS);
  localparam int OFF_W  = BYTE_W + WSEL_W;
  localparam int SET_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - SET_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic              writeQ;

  logic              validQ [SETS][WAYS];
  logic [TAG_W-1:0]  tagQ   [SETS][WAYS];
  logic [LINE_W-1:0] dataQ  [SETS][WAYS];

  logic [SET_W-1:0]  setIdx;
  logic [TAG_W-1:0]  tagIn;
  logic [WSEL_W-1:0] wordSel;
  logic [WAYS-1:0]   matchVec;
  logic [WAYS-1:0]   validVec;
  wayIdx_t           hitWay;
  wayIdx_t           victimWay;
  logic [LINE_W-1:0] hitLine;

  assign setIdx  = addrQ[OFF_W +: SET_W];
  assign tagIn   = addrQ[ADDR_W-1 -: TAG_W];
  assign wordSel = addrQ[BYTE_W +: WSEL_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      writeQ <= 1'b0;
    end else if (strobe.capture) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      writeQ <= reqWrite;
    end
  end

  // parallel tag compare
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign validVec[w] = validQ[setIdx][w];
    assign matchVec[w] = validQ[setIdx][w] && (tagQ[setIdx][w] == tagIn);
  end

  always_comb begin
    hitWay = '0;
    for (int w = 0; w < WAYS; w++)
      if (matchVec[w]) hitWay = WAY_W'(w);
  end

  assign stat.hit   = ($countones(matchVec) == 1);
  assign stat.write = writeQ;
  assign hitLine    = dataQ[setIdx][hitWay];

  assign respRdata = strobe.fill ? memRefillData[wordSel*DATA_W +: DATA_W]
                                 : hitLine[wordSel*DATA_W +: DATA_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          validQ[s][w] <= 1'b0;
    end else if (strobe.fill) begin
      validQ[setIdx][victimWay] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fill) begin
      tagQ[setIdx][victimWay]  <= tagIn;
      dataQ[setIdx][victimWay] <= memRefillData;
    end else if (strobe.writeWord) begin
      dataQ[setIdx][hitWay][wordSel*DATA_W +: DATA_W] <= wdataQ;
    end
  end

  cache_lru #(.SETS(SETS), .SET_W(SET_W)) uLru (
    .clk      (clk),
    .rstN     (rstN),
    .setIdx   (setIdx),
    .touch    (strobe.touchHit | strobe.fill),
    .touchWay (strobe.fill ? victimWay : hitWay),
    .validVec (validVec),
    .victimWay(victimWay)
  );

  assign memReqAddr = {tagIn, setIdx, {OFF_W{1'b0}}};
  assign memWrAddr  = addrQ;
  assign memWrData  = wdataQ;

  assert_single_match_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec));

  assert_fill_hits_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fill |=> stat.hit);
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memRefillValid,
  input  lookupStat_t stat,
  output logic        reqReady,
  output logic        respValid,
  output logic        respHit,
  output logic        memReqValid,
  output logic        memWrValid,
  output ctrlStrobe_t strobe
);
  typedef enum logic [1:0] {ST_IDLE, ST_LOOKUP, ST_REFILL} ctrlState_t;
  ctrlState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext   = state;
    strobe      = '0;
    reqReady    = 1'b0;
    respValid   = 1'b0;
    respHit     = 1'b0;
    memReqValid = 1'b0;
    memWrValid  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady       = 1'b1;
        strobe.capture = reqValid;
        if (reqValid) stateNext = ST_LOOKUP;
      end
      ST_LOOKUP: begin
        if (stat.write) begin
          memWrValid       = 1'b1;
          respValid        = 1'b1;
          respHit          = stat.hit;
          strobe.writeWord = stat.hit;
          strobe.touchHit  = stat.hit;
          stateNext        = ST_IDLE;
        end else if (stat.hit) begin
          respValid       = 1'b1;
          respHit         = 1'b1;
          strobe.touchHit = 1'b1;
          stateNext       = ST_IDLE;
        end else begin
          stateNext = ST_REFILL;
        end
      end
      ST_REFILL: begin
        memReqValid = 1'b1;
        if (memRefillValid) begin
          strobe.fill = 1'b1;
          respValid   = 1'b1;
          stateNext   = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assert_no_refill_on_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !stat.write);

  assert_resp_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid && reqReady);
endmodule

// File: rtl/cache_4way.sv
module cache_4way
  import cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int SETS   = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic                    reqWrite,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [DATA_W-1:0]       reqWdata,
  output logic                    respValid,
  output logic                    respHit,
  output logic [DATA_W-1:0]       respRdata,
  output logic                    memReqValid,
  output logic [ADDR_W-1:0]       memReqAddr,
  input  logic                    memRefillValid,
  input  logic [WORDS*DATA_W-1:0] memRefillData,
  output logic                    memWrValid,
  output logic [ADDR_W-1:0]       memWrAddr,
  output logic [DATA_W-1:0]       memWrData
);
  ctrlStrobe_t strobe;
  lookupStat_t stat;

  cache_ctrl uCtrl (
    .clk           (clk),
    .rstN          (rstN),
    .reqValid      (reqValid),
    .memRefillValid(memRefillValid),
    .stat          (stat),
    .reqReady      (reqReady),
    .respValid     (respValid),
    .respHit       (respHit),
    .memReqValid   (memReqValid),
    .memWrValid    (memWrValid),
    .strobe        (strobe)
  );

  cache_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .SETS(SETS)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .reqAddr      (reqAddr),
    .reqWrite     (reqWrite),
    .reqWdata     (reqWdata),
    .memRefillData(memRefillData),
    .stat         (stat),
    .respRdata    (respRdata),
    .memReqAddr   (memReqAddr),
    .memWrAddr    (memWrAddr),
    .memWrData    (memWrData)
  );
endmodule

// File: tb/cache_4way_test.sv
module cache_4way_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic         reqReady;
  logic         reqWrite = 1'b0;
  logic [31:0]  reqAddr = '0;
  logic [31:0]  reqWdata = '0;
  logic         respValid;
  logic         respHit;
  logic [31:0]  respRdata;
  logic         memReqValid;
  logic [31:0]  memReqAddr;
  logic         memRefillValid = 1'b0;
  logic [127:0] memRefillData = '0;
  logic         memWrValid;
  logic [31:0]  memWrAddr;
  logic [31:0]  memWrData;

  int testsRun = 0;
  int testsFailed = 0;
  logic readyWhileBusy = 1'b0;
  logic [31:0] lastReqAddr;
  logic [31:0] wmem [logic [31:0]];

  always #4 clk = ~clk;  // 125 MHz

  cache_4way uut (.*);

  function automatic logic [31:0] memRead(input logic [31:0] a);
    logic [31:0] wa;
    wa = {a[31:2], 2'b00};
    if (wmem.exists(wa)) return wmem[wa];
    return (wa * 32'h0001_0003) ^ 32'hC0DE_0000;
  endfunction

  function automatic logic [127:0] makeLine(input logic [31:0] b);
    return {memRead(b + 12), memRead(b + 8), memRead(b + 4), memRead(b)};
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one request, served by the bench memory model
  task automatic access(input logic wr, input logic [31:0] addr, input logic [31:0] wd,
                        output logic gotHit, output logic [31:0] gotData,
                        output int refills, output int wrs);
    int guard;
    logic done;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWdata = wd;
    @(posedge clk); #1 reqValid = 1'b0;
    refills = 0; wrs = 0; done = 1'b0; guard = 0;
    gotHit = 1'b0; gotData = '0;
    while (!done && guard < 40) begin
      @(negedge clk);
      guard++;
      if (guard == 1 && reqReady) readyWhileBusy = 1'b1;
      if (memWrValid) begin
        wrs++;
        wmem[{memWrAddr[31:2], 2'b00}] = memWrData;
      end
      if (respValid) begin
        gotHit = respHit; gotData = respRdata; done = 1'b1;
      end else if (memReqValid) begin
        refills++;
        lastReqAddr = memReqAddr;
        repeat (2) @(negedge clk);
        memRefillValid = 1'b1;
        memRefillData = makeLine(lastReqAddr);
        #1;
        gotHit = respHit; gotData = respRdata; done = respValid;
        @(posedge clk); #1 memRefillValid = 1'b0;
      end
    end
    if (!done) check(1'b0, "handshake", 32'(guard), 32'd0);
  endtask

  task automatic expectRead(input logic [31:0] addr, input logic expHit, input string req);
    logic h; logic [31:0] d; int r, w;
    access(1'b0, addr, '0, h, d, r, w);
    check(h == expHit, req, {31'd0, h}, {31'd0, expHit});
    check(d == memRead(addr), req, d, memRead(addr));
    check(r == (expHit ? 0 : 1), req, 32'(r), expHit ? 32'd0 : 32'd1);
  endtask

  task automatic testReset();
    check(reqReady == 1'b1, "R10 ready after reset", {31'd0, reqReady}, 32'd1);
    check({respValid, memReqValid, memWrValid} == 3'b000, "R10 idle outputs",
          {29'd0, respValid, memReqValid, memWrValid}, 32'd0);
  endtask

  task automatic testMissThenHit();
    logic h; logic [31:0] d; int r, w;
    // R4: cold miss in set 2, block 0x20
    access(1'b0, 32'h0000_0024, '0, h, d, r, w);
    check(!h && r == 1, "R4 cold miss", {31'd0, h}, 32'd0);
    check(d == memRead(32'h24), "R4 refill word", d, memRead(32'h24));
    check(lastReqAddr == 32'h0000_0020, "R1 block aligned refill", lastReqAddr, 32'h20);
    // R2: other word of same block hits
    expectRead(32'h0000_002C, 1'b1, "R2 hit same block");
    // R1: tag 1 in set 2 misses with its own block address
    expectRead(32'h0000_0064, 1'b0, "R1 second tag same set");
    check(lastReqAddr == 32'h0000_0060, "R1 refill addr", lastReqAddr, 32'h60);
    expectRead(32'h0000_0020, 1'b1, "R1 first block still present");
  endtask

  task automatic testLruOrder();
    // set 0 blocks: tags A..F at 0x000, 0x040, ...
    for (int k = 0; k < 4; k++) expectRead(32'(k * 64), 1'b0, "R5 fill empty ways");
    for (int k = 0; k < 4; k++) expectRead(32'(k * 64 + 4), 1'b1, "R5 all four resident");
    // ages now A3 B2 C1 D0 after probing in order? probes re-used A..D: A3 B2 C1 D0
    expectRead(32'h000, 1'b1, "R6 touch A");     // A0 B3 C2 D1
    expectRead(32'h100, 1'b0, "R6 miss E");      // evicts B -> E0 A1 C3 D2
    expectRead(32'h000, 1'b1, "R6 A kept");
    expectRead(32'h080, 1'b1, "R6 C kept");
    expectRead(32'h0C0, 1'b1, "R6 D kept");
    expectRead(32'h100, 1'b1, "R6 E kept");      // E0 D1 C2 A3
    expectRead(32'h040, 1'b0, "R6 B was victim");// evicts A
    expectRead(32'h000, 1'b0, "R7 A oldest evicted");
  endtask

  task automatic testWriteHit();
    logic h; logic [31:0] d; int r, w;
    expectRead(32'h0000_00B0, 1'b0, "R8 prime line");
    access(1'b1, 32'h0000_00B8, 32'hFACE_0001, h, d, r, w);
    check(h && w == 1 && r == 0, "R8 write hit", {31'd0, h}, 32'd1);
    check(wmem[32'hB8] == 32'hFACE_0001, "R8 write through data", wmem[32'hB8], 32'hFACE_0001);
    access(1'b0, 32'h0000_00B8, '0, h, d, r, w);
    check(h && d == 32'hFACE_0001, "R8 read back", d, 32'hFACE_0001);
  endtask

  task automatic testWriteMiss();
    logic h; logic [31:0] d; int r, w;
    access(1'b1, 32'h0000_1014, 32'h1234_ABCD, h, d, r, w);
    check(!h && w == 1, "R9 write miss through", {31'd0, h}, 32'd0);
    check(r == 0, "R9 no refill", 32'(r), 32'd0);
    expectRead(32'h0000_1014, 1'b0, "R9 not allocated");
    expectRead(32'h0000_1014, 1'b1, "R9 now cached");
  endtask

  task automatic testBusy();
    check(!readyWhileBusy, "R10 ready low while busy", {31'd0, readyWhileBusy}, 32'd0);
    @(negedge clk);
    check(reqReady, "R10 ready when idle", {31'd0, reqReady}, 32'd1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMissThenHit();
    testLruOrder();
    testWriteHit();
    testWriteMiss();
    testBusy();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule